// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one cache line and decides whether atomic
read-modify-write sequences built from load-linked and store-conditional
requests may complete. Every request carries the issuing CPU number and the
thread number inside that CPU. A load-linked request adds that context to a
small reservation table. A store-conditional asks whether its own context is
still in that table.

A store-conditional succeeds only when its context still holds a reservation.
Any store, conditional or plain, empties the table, and so does an
invalidation of the line. The block also holds the line's status flags and
reports whether the line may be written. Each request takes effect in one
clock cycle. Responses to stores and store-conditionals appear on the next
cycle.

Top module: `llsc_resv_monitor`

## Requirements
- R1: `line_status` bit 0 means valid, bit 1 writable, bit 2 dirty, bit 4 referenced and bit 5 prefetched-but-unused. Bits 3, 6 and 7 always read 0. On each clock edge the register becomes `(old & ~stat_clr) | stat_set`, masked to the implemented bits.
- R2: `can_write` is 1 only when both the valid bit and the writable bit of `line_status` are set.
- R3: A request with `req_valid`=1 and `req_op`=0 (load-linked) records its (`req_cpu`, `req_thread`) pair as a new reservation entry. A later store-conditional from the same context then succeeds.
- R4: A store-conditional succeeds only if some entry matches both its CPU number and its thread number. A match on one field alone does not count.
- R5: A store-conditional (`req_op`=2) gives `resp_valid`=1 in the following cycle. On success it gives `resp_proceed`=1 and `resp_code`=1. On failure it gives `resp_proceed`=0 and `resp_code`=0.
- R6: After any store-conditional, whether it succeeds or fails, the table is empty.
- R7: A plain store (`req_op`=1) gives `resp_valid`=1, `resp_proceed`=1 and `resp_code`=0 in the following cycle, and empties the table.
- R8: `line_inv`=1 empties the table. A store-conditional in the same cycle as `line_inv` fails.
- R9: The table holds NUM_ENT entries (default 4). New entries go in at the front. When the table is full, the oldest entry is dropped. Duplicate entries from one context are allowed.
- R10: Reset clears `line_status`, `resp_valid` and every reservation.
- R11: When a clear (store, store-conditional or `line_inv`) and a load-linked arrive in the same cycle, the clear is applied first. Only the new reservation survives.
- R12: `req_op`=3 with `req_valid`=1 is ignored. It gives no response and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 0 load-linked, 1 store, 2 store-conditional, 3 ignored |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thread | input | THR_W | Thread number of the requester |
| line_inv | input | 1 | Line invalidation, clears all reservations |
| stat_clr | input | 8 | Status bits to clear this cycle |
| stat_set | input | 8 | Status bits to set this cycle |
| line_status | output | 8 | Current status flags |
| can_write | output | 1 | Valid and writable both set |
| resp_valid | output | 1 | Response to a store or store-conditional |
| resp_proceed | output | 1 | The write may proceed |
| resp_code | output | 1 | Store-conditional result, 1 success, 0 failure |

## Verification
The hardest state to reach is a full table in which the oldest entry has just
been pushed out. It can only be seen indirectly, because the one probe that
reads the table also empties it. The bench therefore rebuilds the table from
reset for every probe. It loads sequences of one to six distinct contexts and
then issues a single store-conditional, and it predicts the result from the
insertion order. The same-cycle cases, a clear together with a load-linked and
a store-conditional together with an invalidation, are driven as single-cycle
combinations and then probed the same way.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LL  = 2'd0,
    OP_ST  = 2'd1,
    OP_SC  = 2'd2,
    OP_NOP = 2'd3
  } llsc_op_e;

  localparam int ST_VALID  = 0;
  localparam int ST_WRITE  = 1;
  localparam int ST_DIRTY  = 2;
  localparam int ST_REF    = 4;
  localparam int ST_PFETCH = 5;

  localparam logic [7:0] ST_IMPL_MASK = 8'h37;

  // next status value: clear first, then set, then drop unimplemented bits
  function automatic logic [7:0] st_next(input logic [7:0] cur,
                                         input logic [7:0] clr,
                                         input logic [7:0] set);
    return ((cur & ~clr) | set) & ST_IMPL_MASK;
  endfunction

  function automatic logic st_can_write(input logic [7:0] s);
    return s[ST_VALID] & s[ST_WRITE];
  endfunction

endpackage

// File: rtl/llsc_status_reg.sv
module llsc_status_reg
  import llsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] clr_i,
  input  logic [7:0] set_i,
  output logic [7:0] stat_o,
  output logic       can_write_o
);

  logic [7:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= st_next(stat_q, clr_i, set_i);
  end

  assign stat_o      = stat_q;
  assign can_write_o = st_can_write(stat_q);

  // R1: unimplemented positions never hold a one
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~ST_IMPL_MASK) == 8'h00);

  // R1: a bit requested set shows up on the next cycle
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[ST_VALID] |=> stat_q[ST_VALID]);

  // R2: write permission needs the valid flag
  a_r2_wr_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    can_write_o |-> stat_q[ST_VALID]);

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int NUM_ENT = 4,
  parameter int CPU_W   = 2,
  parameter int THR_W   = 2,
  localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_i,
  input  logic             clr_i,
  input  logic [CPU_W-1:0] ins_cpu_i,
  input  logic [THR_W-1:0] ins_thr_i,
  input  logic [CPU_W-1:0] look_cpu_i,
  input  logic [THR_W-1:0] look_thr_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [NUM_ENT-1:0] vld_q;
  logic [NUM_ENT-1:0] hit_vec;
  logic [CPU_W-1:0]   cpu_q [NUM_ENT];
  logic [THR_W-1:0]   thr_q [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          cpu_q[0] <= '0;
          thr_q[0] <= '0;
        end else if (ins_i) begin
          vld_q[0] <= 1'b1;
          cpu_q[0] <= ins_cpu_i;
          thr_q[0] <= ins_thr_i;
        end else if (clr_i) begin
          vld_q[0] <= 1'b0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          cpu_q[g] <= '0;
          thr_q[g] <= '0;
        end else if (ins_i) begin
          // clear takes effect before the shift-in
          vld_q[g] <= vld_q[g-1] & ~clr_i;
          cpu_q[g] <= cpu_q[g-1];
          thr_q[g] <= thr_q[g-1];
        end else if (clr_i) begin
          vld_q[g] <= 1'b0;
        end
      end
    end
    assign hit_vec[g] = vld_q[g] && (cpu_q[g] == look_cpu_i)
                                 && (thr_q[g] == look_thr_i);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NUM_ENT; i++) cnt_o = cnt_o + CNT_W'(vld_q[i]);
  end

  // R6/R7/R8: a clear with no insertion leaves nothing behind
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !ins_i |=> cnt_o == '0);

  // R11: clear plus insertion leaves exactly the new entry
  a_r11_clear_then_ins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && ins_i |=> (cnt_o == CNT_W'(1)) && vld_q[0]);

  // R9: insertion grows occupancy by one, saturating at capacity
  a_r9_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    ins_i && !clr_i |=> cnt_o == (($past(cnt_o) == CNT_W'(NUM_ENT)) ?
                                  CNT_W'(NUM_ENT) : $past(cnt_o) + CNT_W'(1)));

  // R12: with neither insertion nor clear the table holds still
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_i && !clr_i |=> $stable(vld_q));

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int CPU_W   = 2,
  parameter int THR_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [CPU_W-1:0] req_cpu,
  input  logic [THR_W-1:0] req_thread,
  input  logic             line_inv,
  input  logic [7:0]       stat_clr,
  input  logic [7:0]       stat_set,
  output logic [7:0]       line_status,
  output logic             can_write,
  output logic             resp_valid,
  output logic             resp_proceed,
  output logic             resp_code
);

  localparam int CNT_W = $clog2(NUM_ENT + 1);

  llsc_op_e         op;
  logic             ll_evt, st_evt, sc_evt, clr_evt, sc_ok, tbl_hit;
  logic [CNT_W-1:0] resv_cnt;

  assign op      = llsc_op_e'(req_op);
  assign ll_evt  = req_valid && (op == OP_LL);
  assign st_evt  = req_valid && (op == OP_ST);
  assign sc_evt  = req_valid && (op == OP_SC);
  assign clr_evt = st_evt || sc_evt || line_inv;
  assign sc_ok   = sc_evt && tbl_hit && !line_inv;

  llsc_status_reg u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (stat_clr),
    .set_i       (stat_set),
    .stat_o      (line_status),
    .can_write_o (can_write)
  );

  llsc_resv_table #(
    .NUM_ENT (NUM_ENT),
    .CPU_W   (CPU_W),
    .THR_W   (THR_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_i      (ll_evt),
    .clr_i      (clr_evt),
    .ins_cpu_i  (req_cpu),
    .ins_thr_i  (req_thread),
    .look_cpu_i (req_cpu),
    .look_thr_i (req_thread),
    .hit_o      (tbl_hit),
    .cnt_o      (resv_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_proceed <= 1'b0;
      resp_code    <= 1'b0;
    end else begin
      resp_valid   <= st_evt || sc_evt;
      resp_proceed <= st_evt || sc_ok;
      resp_code    <= sc_ok;
    end
  end

  // R5: a store-conditional answers next cycle with matching flag and code
  a_r5_sc_resp: assert property (@(posedge clk) disable iff (!rst_n)
    sc_evt |=> resp_valid && (resp_proceed == resp_code));

  // R4: a store-conditional against an empty table never succeeds
  a_r4_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
    sc_evt && (resv_cnt == '0) |=> !resp_code);

  // R7: a plain store always proceeds with result code 0
  a_r7_store_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
    st_evt |=> resp_valid && resp_proceed && !resp_code);

  // R8: invalidation in the same cycle defeats a store-conditional
  a_r8_inv_blocks_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_evt && line_inv |=> !resp_proceed);

  // R12: an ignored opcode raises no response
  a_r12_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (op == OP_NOP) |=> !resp_valid);

endmodule

// File: tb/llsc_resv_monitor_tb.sv
`timescale 1ns/1ps
module llsc_resv_monitor_tb;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [1:0] req_cpu = '0;
  logic [1:0] req_thread = '0;
  logic       line_inv = 1'b0;
  logic [7:0] stat_clr = '0;
  logic [7:0] stat_set = '0;
  logic [7:0] line_status;
  logic       can_write, resp_valid, resp_proceed, resp_code;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  llsc_resv_monitor #(.NUM_ENT(N), .CPU_W(2), .THR_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_cpu(req_cpu), .req_thread(req_thread), .line_inv(line_inv),
    .stat_clr(stat_clr), .stat_set(stat_set), .line_status(line_status),
    .can_write(can_write), .resp_valid(resp_valid),
    .resp_proceed(resp_proceed), .resp_code(resp_code));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request for one cycle; returns at the negedge after the capturing edge
  task automatic req(input logic [1:0] op, input int ctx, input logic inv);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_cpu    = 2'(ctx >> 2);
    req_thread = 2'(ctx);
    line_inv   = inv;
    @(negedge clk);
    req_valid  = 1'b0;
    line_inv   = 1'b0;
  endtask

  task automatic inv_only();
    @(negedge clk);
    line_inv = 1'b1;
    @(negedge clk);
    line_inv = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_status(input logic [7:0] c, input logic [7:0] s);
    @(negedge clk);
    stat_clr = c;
    stat_set = s;
    @(negedge clk);
    stat_clr = '0;
    stat_set = '0;
  endtask

  initial begin
    #(4ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10 status", int'(line_status), 0);
    chk("R10 can_write", int'(can_write), 0);
    chk("R10 resp_valid", int'(resp_valid), 0);
    req(2'd2, 5, 1'b0);
    chk("R10 empty table sc", int'(resp_code), 0);

    // R1/R2: status sweep, clear everything then set mask m
    for (int m = 0; m < 256; m++) begin
      set_status(8'hFF, 8'(m));
      chk("R1 status", int'(line_status), m & 8'h37);
      chk("R2 can_write", int'(can_write), ((m & 3) == 3) ? 1 : 0);
    end
    set_status(8'h01, 8'h00);
    chk("R1 clear one bit", int'(line_status), 8'h36);
    chk("R2 writable without valid", int'(can_write), 0);

    // R3/R4/R5: every LL context against every SC context
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        req(2'd0, a, 1'b0);
        req(2'd2, b, 1'b0);
        chk("R5 sc resp_valid", int'(resp_valid), 1);
        chk("R4 sc code", int'(resp_code), (a == b) ? 1 : 0);
        chk("R5 sc proceed", int'(resp_proceed), (a == b) ? 1 : 0);
      end
    end

    // R6: second SC after success fails
    do_reset();
    req(2'd0, 3, 1'b0);
    req(2'd2, 3, 1'b0);
    chk("R6 first sc", int'(resp_code), 1);
    req(2'd2, 3, 1'b0);
    chk("R6 second sc", int'(resp_code), 0);
    // R6: a failed SC also clears
    req(2'd0, 3, 1'b0);
    req(2'd2, 4, 1'b0);
    chk("R6 failed sc code", int'(resp_code), 0);
    req(2'd2, 3, 1'b0);
    chk("R6 cleared after fail", int'(resp_code), 0);

    // R7: plain store
    do_reset();
    req(2'd0, 7, 1'b0);
    req(2'd1, 9, 1'b0);
    chk("R7 store valid", int'(resp_valid), 1);
    chk("R7 store proceed", int'(resp_proceed), 1);
    chk("R7 store code", int'(resp_code), 0);
    req(2'd2, 7, 1'b0);
    chk("R7 store cleared", int'(resp_code), 0);

    // R8: invalidate alone, and alongside SC
    do_reset();
    req(2'd0, 2, 1'b0);
    inv_only();
    req(2'd2, 2, 1'b0);
    chk("R8 inv clears", int'(resp_code), 0);
    do_reset();
    req(2'd0, 2, 1'b0);
    req(2'd2, 2, 1'b1);
    chk("R8 sc with inv", int'(resp_proceed), 0);

    // R11: clear and LL together
    do_reset();
    req(2'd0, 1, 1'b0);
    req(2'd0, 6, 1'b1);
    req(2'd2, 1, 1'b0);
    chk("R11 old dropped", int'(resp_code), 0);
    do_reset();
    req(2'd0, 1, 1'b0);
    req(2'd0, 6, 1'b1);
    req(2'd2, 6, 1'b0);
    chk("R11 new kept", int'(resp_code), 1);

    // R12: ignored opcode
    do_reset();
    req(2'd0, 11, 1'b0);
    req(2'd3, 11, 1'b0);
    chk("R12 no response", int'(resp_valid), 0);
    req(2'd2, 11, 1'b0);
    chk("R12 table kept", int'(resp_code), 1);

    // R9: load contexts 0..L-1 in order, probe context j
    for (int l = 1; l <= 6; l++) begin
      for (int j = 0; j <= 6; j++) begin
        do_reset();
        for (int k = 0; k < l; k++) req(2'd0, k, 1'b0);
        req(2'd2, j, 1'b0);
        chk("R9 capacity", int'(resp_code),
            (j < l && j >= l - N) ? 1 : 0);
      end
    end
    // R9: duplicates occupy separate entries
    do_reset();
    req(2'd0, 8, 1'b0);
    req(2'd0, 8, 1'b0);
    req(2'd0, 9, 1'b0);
    req(2'd0, 10, 1'b0);
    req(2'd0, 12, 1'b0);
    req(2'd0, 13, 1'b0);
    req(2'd2, 8, 1'b0);
    chk("R9 duplicates pushed out", int'(resp_code), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule